// File: doc/BRIEF.md
# Byte-Lane Controller for a 32-bit Asynchronous Static RAM

This block sits between a clocked host and an asynchronous static RAM that is 32 bits wide, 2^19 words deep and built from four 8-bit lanes. Each lane has its own active-low chip select. The host raises a request with a word address, a write flag, write data and a 4-bit lane mask. It holds the request until the controller answers with a one-cycle ready pulse. The controller then produces the memory strobes as a timed sequence: write enable, output enable and one chip select per lane. It also drives the write data with a separate drive-enable. On reads it registers the returned data.

Lanes are chosen only by gating the per-lane chip selects, so any mix of the four lanes can be read or written in a single access. Every timing margin is a count of clock cycles. The defaults come from a clock period parameter through a ceiling function: address setup before the write, the gap before the data bus is driven, data setup and hold around the rising write strobe, and read latency. The write ends when write enable rises while the chip selects are still low, so write enable is the strobe that ends every write. Setup and hold are counted from that edge.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever reset is applied during an access, all four chip selects, write enable and output enable are high, the data drive-enable and ready are low, and the read data register is zero.
- R2: Lane k uses data bits 8k+7..8k and chip select bit k. During an access, mem_cs_n[k] is low exactly when req_mask[k] was 1 at acceptance, and the other lanes stay high. A mask of zero selects no lane, but the access still completes with ready.
- R3: A write keeps its selected chip selects low for SETUP_CYC cycles with write enable high, then PULSE_CYC cycles with write enable low, then HOLD_CYC cycles with write enable high. Output enable stays high for the whole write.
- R4: The data drive-enable rises only after write enable has been low for OFF_CYC cycles. It stays high through the HOLD_CYC cycles after write enable rises. It is never high while output enable is low.
- R5: A read holds its selected chip selects and output enable low for RDLAT_CYC cycles with write enable high. The returned data is registered on the edge that ends the last of those cycles. Bytes of lanes not in the mask read as zero.
- R6: Ready is high for exactly one cycle per access. Counting the accepting edge as the first, ready is visible after edge 1+SETUP_CYC+PULSE_CYC+HOLD_CYC for a write and after edge 1+RDLAT_CYC for a read.
- R7: Address and write data seen by the memory are captured at acceptance and stay fixed while any chip select is low. Changes to the request inputs during an access have no effect on it.
- R8: In the cycle that ready is high, and for at least one cycle between accesses, all chip selects are high. A request is accepted only when the controller is idle.
- R9: The read data output keeps its value until the next read completes. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 32 | Write data, lane k in bits 8k+7..8k |
| req_mask | input | 4 | Lane mask, bit k enables lane k |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Registered read data |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 4 | Per-lane chip selects, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 32 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive-enable for mem_dq_out |
| mem_dq_in | input | 32 | Data returned by the memory |

## Verification
A sequencer stuck in or skipping a phase shows up within one access. The ready pulse then lands on the wrong edge, or the number of low write-enable or drive-enable cycles differs from the parameter sums. A counter that reloads the wrong value stretches or shrinks a strobe by whole cycles, which changes those same counts at once. A mask or lane-index error makes the wrong chip select fall on the first cycle of the access. On reads it also corrupts the zeroed bytes in the very next read result. The drive-enable is timed against write enable, so a slip there is caught on the same cycle.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RWAIT  = 3'd4,
    ST_GAP    = 3'd5
  } seq_state_e;

  // smallest cycle count covering a time in picoseconds
  function automatic int cycles_for(input int time_ps, input int period_ps);
    return (time_ps + period_ps - 1) / period_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic strobes_active(input seq_state_e s);
    return (s == ST_WSETUP) || (s == ST_WPULSE) || (s == ST_WHOLD) || (s == ST_RWAIT);
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_lane_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 4,
  parameter int HOLD_CYC  = 1,
  parameter int RDLAT_CYC = 3,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  output seq_state_e       state_d,
  output logic [CNT_W-1:0] cnt_d,
  output logic             accept,
  output logic             wr_done,
  output logic             rd_done
);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign wr_done  = (state_q == ST_WHOLD) && cnt_zero;
  assign rd_done  = (state_q == ST_RWAIT) && cnt_zero;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        state_d = req_write ? ST_WSETUP : ST_RWAIT;
        cnt_d   = req_write ? CNT_W'(SETUP_CYC - 1) : CNT_W'(RDLAT_CYC - 1);
      end
      ST_WSETUP: if (cnt_zero) begin
        state_d = ST_WPULSE;
        cnt_d   = CNT_W'(PULSE_CYC - 1);
      end
      ST_WPULSE: if (cnt_zero) begin
        state_d = ST_WHOLD;
        cnt_d   = CNT_W'(HOLD_CYC - 1);
      end
      ST_WHOLD: if (cnt_zero) state_d = ST_GAP;
      ST_RWAIT: if (cnt_zero) state_d = ST_GAP;
      ST_GAP: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
  import sram_lane_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int PULSE_CYC = 4,
  parameter int OFF_CYC   = 2,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_state_e       state_d,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [LANES-1:0] mask_d,
  output logic [LANES-1:0] cs_n_q,
  output logic             we_n_q,
  output logic             oe_n_q,
  output logic             dq_oe_q
);

  // counter counts down through the pulse; drive once OFF_CYC cycles have gone
  function automatic logic drive_window(input logic [CNT_W-1:0] cnt);
    return int'(cnt) <= (PULSE_CYC - 1 - OFF_CYC);
  endfunction

  function automatic logic [LANES-1:0] lane_strobes(input logic active,
                                                    input logic [LANES-1:0] mask);
    return active ? ~mask : {LANES{1'b1}};
  endfunction

  logic [LANES-1:0] cs_n_d;
  logic             we_n_d, oe_n_d, dq_oe_d;

  always_comb begin
    cs_n_d  = lane_strobes(strobes_active(state_d), mask_d);
    we_n_d  = (state_d != ST_WPULSE);
    oe_n_d  = (state_d != ST_RWAIT);
    dq_oe_d = ((state_d == ST_WPULSE) && drive_window(cnt_d)) || (state_d == ST_WHOLD);
  end

  // strobes leave registers so the memory never sees decode glitches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q  <= '1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      cs_n_q  <= cs_n_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      dq_oe_q <= dq_oe_d;
    end
  end

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_done,
  input  logic             wr_done,
  input  logic [LANES-1:0] lane_mask,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    rdata_q,
  output logic             ready_q
);

  logic [DW-1:0] merged;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = lane_mask[l] ? dq_in[l*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= rd_done | wr_done;
      if (rd_done) rdata_q <= merged;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int CLK_PS     = 5000,
  parameter int ADDR_W     = 19,
  parameter int LANES      = 4,
  parameter int LANE_W     = 8,
  parameter int SETUP_CYC  = cycles_for(1000, CLK_PS),
  parameter int OFF_CYC    = cycles_for(7000, CLK_PS),
  parameter int DSETUP_CYC = cycles_for(7000, CLK_PS),
  parameter int PULSE_CYC  = max2(cycles_for(10000, CLK_PS), OFF_CYC + DSETUP_CYC),
  parameter int HOLD_CYC   = cycles_for(1000, CLK_PS),
  parameter int RDLAT_CYC  = cycles_for(12000, CLK_PS),
  localparam int DW        = LANES * LANE_W,
  localparam int MAX_CYC   = max2(max2(SETUP_CYC, PULSE_CYC), max2(HOLD_CYC, RDLAT_CYC)),
  localparam int CNT_W     = $clog2(MAX_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              req_ready,
  output logic [DW-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DW-1:0]     mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DW-1:0]     mem_dq_in
);

  seq_state_e       state_d;
  logic [CNT_W-1:0] cnt_d;
  logic             accept, wr_done, rd_done;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q;
  logic [LANES-1:0]  mask_q, mask_d;

  assign mask_d = accept ? req_mask : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  sram_seq_fsm #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC),
    .RDLAT_CYC(RDLAT_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .state_d(state_d), .cnt_d(cnt_d), .accept(accept),
    .wr_done(wr_done), .rd_done(rd_done)
  );

  sram_strobe_gen #(
    .LANES(LANES), .PULSE_CYC(PULSE_CYC), .OFF_CYC(OFF_CYC), .CNT_W(CNT_W)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n), .state_d(state_d), .cnt_d(cnt_d), .mask_d(mask_d),
    .cs_n_q(mem_cs_n), .we_n_q(mem_we_n), .oe_n_q(mem_oe_n), .dq_oe_q(mem_dq_oe)
  );

  sram_read_capture #(.LANES(LANES), .LANE_W(LANE_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .wr_done(wr_done),
    .lane_mask(mask_q), .dq_in(mem_dq_in), .rdata_q(rsp_rdata), .ready_q(req_ready)
  );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W  = 19,
  parameter int LANES   = 4,
  parameter int OFF_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LANES-1:0]  mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              req_ready,
  input logic              accept,
  input logic              wr_done,
  input logic              rd_done
);

  logic [7:0] we_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              we_lo_cnt <= '0;
    else if (mem_we_n)       we_lo_cnt <= '0;
    else if (we_lo_cnt != '1) we_lo_cnt <= we_lo_cnt + 8'd1;
  end

  // R3
  write_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R5
  read_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);

  // R4
  drive_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (!mem_we_n && (int'(we_lo_cnt) >= OFF_CYC)));

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R4
  drive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> (mem_we_n && $past(mem_we_n)));

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n == '1));

  // R8
  done_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done || rd_done) |=> (mem_cs_n == '1));

  // R8
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ((mem_cs_n == '1) && !req_ready && mem_we_n));

  // R7
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_cs_n != '1) && $past(mem_cs_n != '1)) |-> $stable(mem_addr));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .OFF_CYC(OFF_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr),
  .req_ready(req_ready), .accept(accept), .wr_done(wr_done), .rd_done(rd_done)
);

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;

  // timing counts restated for a 5 ns clock: ceil(t/5)
  localparam int T_SET  = 1;   // 1 ns address setup
  localparam int T_OFF  = 2;   // 7 ns output turn-off
  localparam int T_PUL  = 4;   // turn-off plus 7 ns data setup, above 10 ns
  localparam int T_HLD  = 1;   // 1 ns data hold
  localparam int T_LAT  = 3;   // 12 ns read access
  localparam int WR_LAT = 1 + T_SET + T_PUL + T_HLD;
  localparam int RD_LAT = 1 + T_LAT;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [18:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_mask;
  logic        req_ready;
  logic [31:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_we_n, mem_oe_n, mem_dq_oe;
  logic [31:0] mem_dq_out, mem_dq_in;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sram_lane_ctrl u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // small memory model indexed by the low address bits
  logic [31:0] model_mem [16];

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) model_mem[i] <= '0;
    end else if (!mem_we_n && mem_dq_oe) begin
      for (int l = 0; l < 4; l++)
        if (!mem_cs_n[l]) model_mem[mem_addr[3:0]][l*8 +: 8] <= mem_dq_out[l*8 +: 8];
    end
  end

  always_comb begin
    for (int l = 0; l < 4; l++)
      mem_dq_in[l*8 +: 8] = (!mem_cs_n[l] && mem_we_n && !mem_oe_n)
                            ? model_mem[mem_addr[3:0]][l*8 +: 8] : 8'hEE;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, expv);
    end
  endtask

  // one access; with scramble the request inputs change once it is accepted
  task automatic run_access(input logic wr, input logic [18:0] a, input logic [31:0] d,
                            input logic [3:0] m, input logic [31:0] ex, input bit scramble);
    int n = 0, we_lo = 0, drv = 0, oe_lo = 0, sel = 0, bad_lane = 0, ovl = 0, abad = 0;
    logic [31:0] held = rsp_rdata;
    logic [3:0]  cs_at_ready = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (n < 60) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (scramble) begin
        req_write = ~wr; req_addr = a ^ 19'h00006; req_wdata = ~d; req_mask = ~m;
      end
      if (!mem_we_n) we_lo++;
      if (mem_dq_oe) drv++;
      if (!mem_oe_n) oe_lo++;
      if (mem_dq_oe && !mem_oe_n) ovl++;
      if (mem_cs_n != 4'hF && mem_cs_n == ~m) sel++;
      if (mem_cs_n != 4'hF && mem_cs_n != ~m) bad_lane++;
      if (mem_cs_n != 4'hF && mem_addr != a) abad++;
      if (req_ready) begin
        cs_at_ready = mem_cs_n;
        break;
      end
    end
    req_valid = 1'b0;
    chk(n == (wr ? WR_LAT : RD_LAT), "R6 ready edge", 32'(n), 32'(wr ? WR_LAT : RD_LAT));
    chk(we_lo == (wr ? T_PUL : 0), "R3 write-enable low cycles", 32'(we_lo), 32'(wr ? T_PUL : 0));
    chk(drv == (wr ? T_PUL - T_OFF + T_HLD : 0), "R4 drive-enable cycles", 32'(drv),
        32'(wr ? T_PUL - T_OFF + T_HLD : 0));
    chk(ovl == 0, "R4 drive while output enabled", 32'(ovl), 32'd0);
    chk(oe_lo == (wr ? 0 : T_LAT), "R5 output-enable low cycles", 32'(oe_lo), 32'(wr ? 0 : T_LAT));
    chk(bad_lane == 0 && sel == ((m == 4'h0) ? 0 : (wr ? T_SET + T_PUL + T_HLD : T_LAT)),
        "R2 lane selects", 32'(sel), 32'((m == 4'h0) ? 0 : (wr ? T_SET + T_PUL + T_HLD : T_LAT)));
    chk(abad == 0, "R7 address during access", 32'(abad), 32'd0);
    chk(cs_at_ready == 4'hF, "R8 deselect at ready", 32'(cs_at_ready), 32'hF);
    if (!wr) chk(rsp_rdata == ex, "R5 read data", rsp_rdata, ex);
    else     chk(rsp_rdata == held, "R9 read data kept over write", rsp_rdata, held);
    req_write = 1'b0; req_addr = '0; req_wdata = '0; req_mask = '0;
  endtask

  // {write, addr[18:0], wdata[31:0], mask[3:0], expected[31:0]}
  localparam int NV = 11;
  localparam logic [87:0] VEC [NV] = '{
    {1'b1, 19'h00003, 32'h11223344, 4'hF, 32'h00000000},
    {1'b0, 19'h00003, 32'h00000000, 4'hF, 32'h11223344},
    {1'b1, 19'h00003, 32'hAABBCCDD, 4'h5, 32'h00000000},
    {1'b0, 19'h00003, 32'h00000000, 4'hF, 32'h11BB33DD},
    {1'b0, 19'h00003, 32'h00000000, 4'hA, 32'h11003300},
    {1'b1, 19'h00007, 32'hCAFEF00D, 4'hF, 32'h00000000},
    {1'b1, 19'h00007, 32'h00000000, 4'h0, 32'h00000000},
    {1'b0, 19'h00007, 32'h00000000, 4'hF, 32'hCAFEF00D},
    {1'b1, 19'h7FFFF, 32'hDEADBEEF, 4'h8, 32'h00000000},
    {1'b0, 19'h7FFFF, 32'h00000000, 4'hF, 32'hDE000000},
    {1'b0, 19'h00003, 32'h00000000, 4'h0, 32'h00000000}
  };

  task automatic check_idle(input string rq);
    chk(mem_cs_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready,
        rq, {25'd0, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, {25'd0, 4'hF, 3'b110});
    chk(rsp_rdata == 32'h0, rq, rsp_rdata, 32'h0);
  endtask

  task automatic run_all();
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R1 reset state");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_access(VEC[i][87], VEC[i][86:68], VEC[i][67:36], VEC[i][35:32], VEC[i][31:0], 1'b0);

    // R9: read result survives a later write
    run_access(1'b0, 19'h00007, 32'h0, 4'hF, 32'hCAFEF00D, 1'b0);
    run_access(1'b1, 19'h00007, 32'h0, 4'hF, 32'h0, 1'b0);
    chk(rsp_rdata == 32'hCAFEF00D, "R9 read data held", rsp_rdata, 32'hCAFEF00D);

    // R7: inputs scrambled during a write have no effect
    run_access(1'b1, 19'h00003, 32'h01020304, 4'hF, 32'h0, 1'b1);
    run_access(1'b0, 19'h00003, 32'h0, 4'hF, 32'h01020304, 1'b0);
    run_access(1'b0, 19'h00005, 32'h0, 4'hF, 32'h00000000, 1'b0);

    // R1: reset in the middle of a write
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h9; req_wdata = 32'h77777777; req_mask = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    check_idle("R1 reset mid-access");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 idle after reset release");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 100000, 0);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule